// File: doc/BRIEF.md
# Transmit Descriptor Queue Engine

This block steps through a ring of two-word transmit descriptors held in an external memory that offers a read port with one cycle of latency and a write port. For each buffer it reads the buffer pointer and the control word. It then issues a single-cycle handoff that carries the buffer address, the length, the end-of-frame flag and the no-CRC flag to the frame transmitter. When the transmitter reports that the frame is complete, the engine writes a status word back into the control word of the frame's first descriptor.

Software controls the engine through three registers, each reached by a two-bit register address: control at 0, queue base at 1 and status at 2. The control register holds an enable bit, a start strobe and a halt strobe. Ownership is passed through the used bit, and the ring can close at any descriptor through the wrap bit. A halt request waits until the frame in flight has finished. After an abort, a new start resumes at the first descriptor of the frame that was interrupted. A pause input holds off the next frame fetch and leaves the run state as it is.

Top module: `txdq_engine`

## Requirements
- R1: After reset the control, base and status registers read as zero. No memory access and no buffer handoff take place until a start is written.
- R2: Descriptor word 0, at the descriptor address, is the buffer address. In word 1, at the descriptor address plus 4, bits 13:0 are the length, bit 15 marks the last buffer of a frame and bit 16 suppresses the CRC. Each descriptor that is not used produces exactly one `ftx_valid` pulse, and the pulses come in ring order.
- R3: When bit 31 (used) of word 1 reads as one on the first buffer of a frame, there is no handoff and the status go bit (status bit 3) clears. The next start reads that same descriptor again.
- R4: When bit 30 (wrap) of word 1 is set, the next descriptor is fetched from the queue base. Otherwise the next descriptor is at the current address plus 8.
- R5: Each completed frame causes exactly one memory write, to word 1 of its first descriptor. That write sets bit 31 to one when the frame succeeded and to zero when it failed. It puts the error code in bits 29:20, or zero on success, and keeps bits 30 and 19:0. No other descriptor is written.
- R6: A write to the base register is accepted only while go is clear and no frame is in progress. The accepted value is stored with bits 2:0 cleared, and the walk restarts from it. A write at any other time leaves the base register unchanged.
- R7: Writing control bit 3 (enable) to zero clears go and returns the walk to the queue base. A start written while enable is zero leaves go clear.
- R8: Writing control bit 9 (start) sets go when enable is one. Writing start again while go is already set changes neither go nor the sequence of buffers.
- R9: Writing control bit 10 (halt) clears go at once when the engine is idle. During a frame, go stays set until the write-back has finished, and no further frame starts. The walk position is kept, so the next start continues with the following descriptor.
- R10: A frame completion flagged with an error clears go, and the next start hands off the first descriptor of the failed frame again.
- R11: A used bit met after a non-last buffer of a frame raises `tx_err_o` and `bad_fcs_o` together for one cycle, clears go and writes no status. The next start resumes at the frame's first descriptor.
- R12: While `pause_i` is high, no new frame fetch begins and go keeps its value. Fetching resumes once the pause is released.
- R13: Descriptor addresses are always multiples of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 base, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| pause_i | input | 1 | Holds off the next frame fetch |
| mem_rd_en | output | 1 | Descriptor read request |
| mem_wr_en | output | 1 | Status write request |
| mem_addr | output | 32 | Byte address for the read or the write |
| mem_wdata | output | 32 | Status word to write |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd_en` |
| ftx_valid | output | 1 | One-cycle buffer handoff |
| ftx_addr | output | 32 | Buffer address |
| ftx_len | output | 14 | Buffer length |
| ftx_last | output | 1 | Last buffer of the frame |
| ftx_crc_off | output | 1 | Do not append CRC |
| frame_done | input | 1 | Frame transmission finished |
| frame_err | input | 1 | Frame ended with an error (valid with `frame_done`) |
| frame_err_code | input | 10 | Error code stored in the status word |
| tx_err_o | output | 1 | Pulse on a mid-frame used descriptor |
| bad_fcs_o | output | 1 | Pulse telling the transmitter to corrupt the FCS |

## Verification
The hardest situations to reach from the ports come from timing. One is a halt or a base-register write that arrives while a frame is still waiting for completion. Another is an ownership bit that turns up after a non-last buffer. To reach the first, the bench's transmitter model holds `frame_done` back for tens of cycles, and the register writes land inside that window. To reach the second, the bench memory holds a two-buffer frame whose second descriptor is still owned. The bench releases that descriptor only after checking the abort, so that the restart can be seen to begin at the first buffer again.

// File: rtl/txdq_pkg.sv
package txdq_pkg;
  localparam int DW       = 32;
  localparam int B_USED   = 31;
  localparam int B_WRAP   = 30;
  localparam int ERR_W    = 10;
  localparam int B_CRCOFF = 16;
  localparam int B_LAST   = 15;
  localparam int LEN_W    = 14;
  localparam int KEEP_W   = 21;   // wrap bit plus bits 19:0
  localparam int C_EN     = 3;
  localparam int C_START  = 9;
  localparam int C_HALT   = 10;
  localparam int S_GO     = 3;
  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_BASE = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  typedef enum logic [2:0] {
    W_IDLE, W_RD0, W_RD1, W_EVAL, W_WAIT, W_WB
  } wstate_e;

  // Next descriptor address: back to base on wrap, else one 8-byte step.
  function automatic logic [DW-1:0] adv_ptr(input logic [DW-1:0] cur,
                                            input logic [DW-1:0] base,
                                            input logic wrap);
    return wrap ? base : cur + DW'(8);
  endfunction

  // Status word: ownership result, kept wrap bit, error code, kept low bits.
  function automatic logic [DW-1:0] status_word(input logic [KEEP_W-1:0] keep,
                                                input logic ok,
                                                input logic [ERR_W-1:0] code);
    return {ok, keep[KEEP_W-1], code, keep[KEEP_W-2:0]};
  endfunction
endpackage

// File: rtl/txdq_ctl.sv
module txdq_ctl import txdq_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          pause_i,
  input  logic          walker_idle,
  input  logic          ev_stop,
  output logic          en_q,
  output logic          go_q,
  output logic          fetch_ok,
  output logic          base_load_q,
  output logic [DW-1:0] base_q
);
  logic halt_pend_q, go_d, halt_pend_d;
  logic wr_ctrl, start_w, halt_w, en_n, base_try, base_ok;

  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign start_w  = wr_ctrl && reg_wdata[C_START];
  assign halt_w   = wr_ctrl && reg_wdata[C_HALT];
  assign en_n     = wr_ctrl ? reg_wdata[C_EN] : en_q;
  assign base_try = reg_wr && (reg_addr == RA_BASE);
  assign base_ok  = base_try && walker_idle && !go_q;
  assign fetch_ok = go_q && en_q && en_n && !halt_pend_q && !halt_w && !pause_i;

  always_comb begin
    go_d        = go_q;
    halt_pend_d = halt_pend_q;
    if (!en_n) begin
      go_d = 1'b0;
    end else begin
      if (ev_stop) go_d = 1'b0;
      if (halt_w) begin
        if (walker_idle) go_d = 1'b0;
        else             halt_pend_d = 1'b1;
      end else if (start_w) begin
        go_d        = 1'b1;
        halt_pend_d = 1'b0;
      end else if (halt_pend_q && walker_idle) begin
        go_d = 1'b0;
      end
    end
    if (!go_d) halt_pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      go_q        <= 1'b0;
      halt_pend_q <= 1'b0;
      base_q      <= '0;
      base_load_q <= 1'b0;
    end else begin
      en_q        <= en_n;
      go_q        <= go_d;
      halt_pend_q <= halt_pend_d;
      base_load_q <= base_ok;
      if (base_ok) base_q <= reg_wdata & ~DW'(7);
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = DW'(en_q) << C_EN;
      RA_BASE: reg_rdata = base_q;
      RA_STAT: reg_rdata = DW'(go_q) << S_GO;
      default: reg_rdata = '0;
    endcase
  end

  // R6: a base write outside the idle, stopped state changes nothing
  assert_base_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (base_try && !(walker_idle && !go_q)) |=> $stable(base_q));
  // R7: the run flag never stays up without enable
  assert_go_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> en_q);
  // R9: a halt on an idle engine takes effect at once
  assert_halt_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_w && walker_idle) |=> !go_q);
endmodule

// File: rtl/txdq_walker.sv
module txdq_walker import txdq_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_q,
  input  logic             fetch_ok,
  input  logic             base_load_q,
  input  logic [DW-1:0]    base_q,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             ftx_valid,
  output logic [DW-1:0]    ftx_addr,
  output logic [LEN_W-1:0] ftx_len,
  output logic             ftx_last,
  output logic             ftx_crc_off,
  input  logic             frame_done,
  input  logic             frame_err,
  input  logic [ERR_W-1:0] frame_err_code,
  output logic             tx_err_o,
  output logic             bad_fcs_o,
  output logic             walker_idle,
  output logic             ev_stop
);
  wstate_e st_q;
  logic [DW-1:0]     ptr_q, first_q, w0_q;
  logic [KEEP_W-1:0] keep_q;
  logic              mid_q, ok_q;
  logic [ERR_W-1:0]  code_q;

  logic evaluating, desc_used, ev_used_first, ev_used_mid, ev_accept, ev_mac_err;
  assign evaluating    = (st_q == W_EVAL);
  assign desc_used     = mem_rdata[B_USED];
  assign ev_used_first = evaluating && desc_used && !mid_q;
  assign ev_used_mid   = evaluating && desc_used && mid_q;
  assign ev_accept     = evaluating && !desc_used;
  assign ev_mac_err    = (st_q == W_WAIT) && frame_done && frame_err;
  assign ev_stop       = ev_used_first || ev_used_mid || ev_mac_err;
  assign walker_idle   = (st_q == W_IDLE);

  assign mem_rd_en   = (st_q == W_RD0) || (st_q == W_RD1);
  assign mem_wr_en   = (st_q == W_WB);
  assign mem_wdata   = status_word(keep_q, ok_q, code_q);
  always_comb begin
    case (st_q)
      W_RD1:   mem_addr = ptr_q + DW'(4);
      W_WB:    mem_addr = first_q + DW'(4);
      default: mem_addr = ptr_q;
    endcase
  end

  assign ftx_valid   = ev_accept;
  assign ftx_addr    = w0_q;
  assign ftx_len     = mem_rdata[LEN_W-1:0];
  assign ftx_last    = mem_rdata[B_LAST];
  assign ftx_crc_off = mem_rdata[B_CRCOFF];
  assign tx_err_o    = ev_used_mid;
  assign bad_fcs_o   = ev_used_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      ptr_q   <= '0;
      first_q <= '0;
      w0_q    <= '0;
      keep_q  <= '0;
      mid_q   <= 1'b0;
      ok_q    <= 1'b0;
      code_q  <= '0;
    end else if (!en_q) begin
      st_q  <= W_IDLE;
      mid_q <= 1'b0;
      ptr_q <= base_q;
    end else begin
      case (st_q)
        W_IDLE: begin
          if (base_load_q) ptr_q <= base_q;
          if (fetch_ok)    st_q  <= W_RD0;
        end
        W_RD0: st_q <= W_RD1;
        W_RD1: begin
          w0_q <= mem_rdata;
          st_q <= W_EVAL;
        end
        W_EVAL: begin
          if (desc_used) begin
            if (mid_q) ptr_q <= first_q;
            mid_q <= 1'b0;
            st_q  <= W_IDLE;
          end else begin
            if (!mid_q) begin
              first_q <= ptr_q;
              keep_q  <= {mem_rdata[B_WRAP], mem_rdata[19:0]};
            end
            ptr_q <= adv_ptr(ptr_q, base_q, mem_rdata[B_WRAP]);
            if (mem_rdata[B_LAST]) begin
              mid_q <= 1'b0;
              st_q  <= W_WAIT;
            end else begin
              mid_q <= 1'b1;
              st_q  <= W_RD0;
            end
          end
        end
        W_WAIT: begin
          if (frame_done) begin
            ok_q   <= !frame_err;
            code_q <= frame_err ? frame_err_code : '0;
            if (frame_err) ptr_q <= first_q;
            st_q   <= W_WB;
          end
        end
        W_WB:    st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  // R13: the walk position stays on an 8-byte boundary
  assert_ptr_align_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q[2:0] == 3'd0);
  // R3: an owned first descriptor leaves the position untouched
  assert_used_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_used_first && en_q) |=> (ptr_q == $past(ptr_q)));
  // R5: completion is followed by one write to the first descriptor's word 1
  assert_wb_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == W_WAIT) && frame_done && en_q) |=>
      (!en_q || (mem_wr_en && mem_addr == $past(first_q) + DW'(4))));
  // R11: a mid-frame owned descriptor rewinds and writes nothing
  assert_mid_rewind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_used_mid && en_q) |=> (!mem_wr_en && ptr_q == $past(first_q)));
endmodule

// File: rtl/txdq_engine.sv
module txdq_engine import txdq_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             pause_i,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             ftx_valid,
  output logic [31:0]      ftx_addr,
  output logic [13:0]      ftx_len,
  output logic             ftx_last,
  output logic             ftx_crc_off,
  input  logic             frame_done,
  input  logic             frame_err,
  input  logic [9:0]       frame_err_code,
  output logic             tx_err_o,
  output logic             bad_fcs_o
);
  logic          en_q, go_q, fetch_ok, base_load_q, walker_idle, ev_stop;
  logic [DW-1:0] base_q;

  txdq_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pause_i(pause_i),
    .walker_idle(walker_idle), .ev_stop(ev_stop), .en_q(en_q), .go_q(go_q),
    .fetch_ok(fetch_ok), .base_load_q(base_load_q), .base_q(base_q)
  );

  txdq_walker u_walk (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .fetch_ok(fetch_ok),
    .base_load_q(base_load_q), .base_q(base_q), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ftx_valid(ftx_valid), .ftx_addr(ftx_addr),
    .ftx_len(ftx_len), .ftx_last(ftx_last), .ftx_crc_off(ftx_crc_off),
    .frame_done(frame_done), .frame_err(frame_err),
    .frame_err_code(frame_err_code), .tx_err_o(tx_err_o),
    .bad_fcs_o(bad_fcs_o), .walker_idle(walker_idle), .ev_stop(ev_stop)
  );

  // R12: no descriptor read follows an idle cycle under pause
  assert_pause_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (walker_idle && pause_i) |=> !mem_rd_en);
endmodule

// File: tb/sim_txdq_engine.sv
`timescale 1ns/1ps
module sim_txdq_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        pause_i = 1'b0;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        ftx_valid, ftx_last, ftx_crc_off;
  logic [31:0] ftx_addr;
  logic [13:0] ftx_len;
  logic        frame_done = 1'b0, frame_err = 1'b0;
  logic [9:0]  frame_err_code = '0;
  logic        tx_err_o, bad_fcs_o;

  always #2 clk = ~clk;   // 250 MHz

  txdq_engine u0 (.*);

  int nchk = 0, nfail = 0;
  logic [31:0] mem [0:63];
  logic [47:0] hq [$];
  logic [63:0] wq [$];
  int rd_cnt = 0, err_cnt = 0, fcs_cnt = 0;
  logic [31:0] last_rd = '0;
  int mac_delay = 3, mac_cnt = 0;
  logic mac_err = 1'b0;
  logic [9:0] mac_code = '0;

  // memory with one cycle of read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[7:2]];
    if (mem_wr_en) mem[mem_addr[7:2]] = mem_wdata;
  end

  // transmitter model: finishes a frame mac_delay cycles after its last buffer
  always @(posedge clk) begin
    frame_done <= 1'b0;
    if (ftx_valid && ftx_last) mac_cnt <= mac_delay;
    else if (mac_cnt != 0) begin
      mac_cnt <= mac_cnt - 1;
      if (mac_cnt == 1) begin
        frame_done     <= 1'b1;
        frame_err      <= mac_err;
        frame_err_code <= mac_code;
      end
    end
  end

  // observer, sampled away from the active edge
  always @(negedge clk) begin
    if (ftx_valid) hq.push_back({ftx_addr, ftx_len, ftx_last, ftx_crc_off});
    if (mem_wr_en) wq.push_back({mem_addr, mem_wdata});
    if (mem_rd_en) begin rd_cnt++; last_rd = mem_addr; end
    if (tx_err_o) err_cnt++;
    if (bad_fcs_o) fcs_cnt++;
  end

  function automatic logic [31:0] mk(input bit used, wrap, last, crcoff,
                                     input int len);
    return {used, wrap, 10'd0, 3'd0, crcoff, last, 1'b0, 14'(len)};
  endfunction
  function automatic logic [31:0] stw(input logic [31:0] w1, input bit ok,
                                      input logic [9:0] code);
    return {ok, w1[30], code, w1[19:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic chk_go(input bit exp, input string tag);
    logic [31:0] v;
    rd(2'd2, v);
    check(v[3] == exp, tag, 64'(v[3]), 64'(exp));
  endtask

  task automatic chk_buf(input int i, input logic [31:0] w0, input logic [31:0] w1,
                         input string tag);
    logic [47:0] e;
    e = {w0, w1[13:0], w1[15], w1[16]};
    if (hq.size() > i) check(hq[i] == e, tag, 64'(hq[i]), 64'(e));
    else check(1'b0, tag, 64'(hq.size()), 64'(i + 1));
  endtask

  task automatic chk_wb(input int i, input logic [31:0] a, input logic [31:0] d,
                        input string tag);
    if (wq.size() > i) check(wq[i] == {a, d}, tag, wq[i], {a, d});
    else check(1'b0, tag, 64'(wq.size()), 64'(i + 1));
  endtask

  task automatic clr();
    hq.delete(); wq.delete();
    err_cnt = 0; fcs_cnt = 0; last_rd = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int rd0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    idle(5);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state
    rd(2'd0, v); check(v == 0, "R1 control after reset", 64'(v), 0);
    rd(2'd1, v); check(v == 0, "R1 base after reset", 64'(v), 0);
    rd(2'd2, v); check(v == 0, "R1 status after reset", 64'(v), 0);
    check(rd_cnt == 0 && hq.size() == 0, "R1 no activity", 64'(rd_cnt), 0);

    // ring at 0x00: single frame, then a two-buffer frame ending in wrap
    mem[0] = 32'h1000; mem[1] = mk(0, 0, 1, 0, 100);
    mem[2] = 32'h2000; mem[3] = mk(0, 0, 0, 1, 60);
    mem[4] = 32'h3000; mem[5] = mk(0, 1, 1, 1, 40);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h208);
    idle(80);
    check(hq.size() == 3, "R2 buffer count", 64'(hq.size()), 3);
    chk_buf(0, 32'h1000, mk(0, 0, 1, 0, 100), "R2 first buffer");
    chk_buf(1, 32'h2000, mk(0, 0, 0, 1, 60), "R2 second buffer");
    chk_buf(2, 32'h3000, mk(0, 1, 1, 1, 40), "R4 wrap buffer");
    check(wq.size() == 2, "R5 one write per frame", 64'(wq.size()), 2);
    chk_wb(0, 32'h04, stw(mk(0, 0, 1, 0, 100), 1, 0), "R5 status frame one");
    chk_wb(1, 32'h0C, stw(mk(0, 0, 0, 1, 60), 1, 0), "R5 status first of frame two");
    check(mem[5] == mk(0, 1, 1, 1, 40), "R5 non-first untouched", 64'(mem[5]),
          64'(mk(0, 1, 1, 1, 40)));
    check(last_rd == 32'h04, "R4 wrap fetch from base", 64'(last_rd), 4);
    chk_go(0, "R3 used bit stops go");

    // R3: restart reads the same owned descriptor again
    clr();
    wr(2'd0, 32'h208);
    idle(20);
    check(hq.size() == 0, "R3 no handoff on used", 64'(hq.size()), 0);
    check(last_rd == 32'h04, "R3 same descriptor reread", 64'(last_rd), 4);
    chk_go(0, "R3 go clear again");

    // ring at 0x80; base write with low bits set
    mem[32] = 32'h5000; mem[33] = mk(0, 0, 1, 0, 200);
    mem[34] = 32'h6000; mem[35] = mk(0, 0, 1, 0, 300);
    mem[36] = 32'h0;    mem[37] = mk(1, 0, 1, 0, 0);
    wr(2'd1, 32'h85);
    rd(2'd1, v); check(v == 32'h80, "R13 base aligned on write", 64'(v), 64'h80);
    clr();
    mac_delay = 30;
    wr(2'd0, 32'h208);
    idle(8);
    wr(2'd1, 32'h0);
    rd(2'd1, v); check(v == 32'h80, "R6 base write ignored while running", 64'(v), 64'h80);
    wr(2'd0, 32'h208);
    chk_go(1, "R8 start rewrite keeps go");
    wr(2'd0, 32'h408);
    chk_go(1, "R9 halt deferred during frame");
    idle(50);
    check(hq.size() == 1, "R9 no frame after halt", 64'(hq.size()), 1);
    chk_buf(0, 32'h5000, mk(0, 0, 1, 0, 200), "R8 sequence unchanged");
    chk_wb(0, 32'h84, stw(mk(0, 0, 1, 0, 200), 1, 0), "R9 frame completed before halt");
    chk_go(0, "R9 go clear after frame");
    clr();
    mac_delay = 3;
    wr(2'd0, 32'h208);
    idle(40);
    chk_buf(0, 32'h6000, mk(0, 0, 1, 0, 300), "R9 resume at following descriptor");
    check(hq.size() == 1, "R9 resume count", 64'(hq.size()), 1);

    // R7: disable returns to base; start while disabled is ignored
    wr(2'd0, 32'h0);
    wr(2'd0, 32'h200);
    chk_go(0, "R7 start ignored when disabled");
    mem[33] = mk(0, 0, 1, 0, 200);
    mem[35] = mk(0, 0, 1, 0, 300);
    clr();
    pause_i = 1'b1;
    rd0 = rd_cnt;
    wr(2'd0, 32'h208);
    idle(20);
    check(rd_cnt == rd0 && hq.size() == 0, "R12 no fetch while paused",
          64'(rd_cnt - rd0), 0);
    chk_go(1, "R12 go kept during pause");
    wr(2'd0, 32'h408);
    chk_go(0, "R9 halt immediate when idle");
    wr(2'd0, 32'h208);
    pause_i = 1'b0;
    idle(60);
    check(hq.size() == 2, "R12 fetch resumes", 64'(hq.size()), 2);
    chk_buf(0, 32'h5000, mk(0, 0, 1, 0, 200), "R7 walk restarts at base");

    // R10: transmitter error rewinds to the failed frame
    mem[33] = mk(0, 0, 1, 0, 200);
    mem[35] = mk(0, 0, 1, 0, 300);
    wr(2'd1, 32'h80);
    clr();
    mac_err = 1'b1; mac_code = 10'h2A5;
    wr(2'd0, 32'h208);
    idle(30);
    mac_err = 1'b0; mac_code = '0;
    check(hq.size() == 1, "R10 stop after error", 64'(hq.size()), 1);
    chk_wb(0, 32'h84, stw(mk(0, 0, 1, 0, 200), 0, 10'h2A5), "R5 error status");
    chk_go(0, "R10 go clear on error");
    clr();
    wr(2'd0, 32'h208);
    idle(60);
    chk_buf(0, 32'h5000, mk(0, 0, 1, 0, 200), "R10 resend failed frame");
    chk_buf(1, 32'h6000, mk(0, 0, 1, 0, 300), "R10 then next frame");

    // R11: used bit after a non-last buffer
    mem[0] = 32'h7000; mem[1] = mk(0, 0, 0, 0, 16);
    mem[2] = 32'h7800; mem[3] = mk(1, 0, 1, 0, 24);
    wr(2'd1, 32'h0);
    clr();
    wr(2'd0, 32'h208);
    idle(30);
    check(err_cnt == 1 && fcs_cnt == 1, "R11 error and bad FCS pulse", 64'(err_cnt), 1);
    check(hq.size() == 1 && wq.size() == 0, "R11 no status written",
          64'(wq.size()), 0);
    chk_go(0, "R11 go clear");
    mem[3] = mk(0, 1, 1, 0, 24);
    clr();
    wr(2'd0, 32'h208);
    idle(40);
    chk_buf(0, 32'h7000, mk(0, 0, 0, 0, 16), "R11 restart at first buffer");
    chk_buf(1, 32'h7800, mk(0, 1, 1, 0, 24), "R11 second buffer sent");
    chk_wb(0, 32'h04, stw(mk(0, 0, 0, 0, 16), 1, 0), "R11 status to first buffer");

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule